// File: doc/BRIEF.md
# Four-Lane Framed Serial ADC Receiver

This block receives sample data from a converter that sends four serial lanes next to a frame clock. A bit-slot enable marks each slot. On every enabled slot the block takes one bit from each lane and one sample of the frame clock. A low-to-high change of the frame clock between two slots marks the first bit of a new word. Each lane is shifted in most significant bit first. After eight bits, the four words are presented together with a one-cycle valid strobe.

The transmitter's lock indicator is active low. It passes through a two-flop synchroniser before use. While the synchronised indicator shows no lock, nothing is captured and any partly assembled word is thrown away. Capture resumes only at the next frame-clock rising edge after lock returns. A format input selects how incoming words are treated: when it marks them as offset binary, the top bit of each lane word is inverted, so the output is always two's complement. A frame edge that arrives before a word is complete drops the partial word and sets a sticky alignment-error flag. A clear input resets that flag.

Top module: `adc_frame_rx`

## Requirements
- R1: After reset, valid_o and align_err_o are 0 and word_o is all zeros.
- R2: A word starts on an enabled slot where frame_i is 1 and frame_i was 0 on the previous enabled slot. Enabled slots before the first such edge are ignored.
- R3: Bits are shifted in MSB first. Lane k's word appears in word_o[8k+7:8k]. valid_o is 1 for exactly one cycle, in the cycle after the clock edge that captures the eighth slot. word_o holds its value until the next word.
- R4: Cycles with bit_en_i low capture nothing, so idle gaps between slots do not change the assembled words.
- R5: With fmt_offset_i at 1 when the eighth slot is captured, bit 7 of every lane word is inverted. With fmt_offset_i at 0, words pass unchanged.
- R6: lock_ni is synchronised through two flops. While it reads 1, no slot is captured and no word is produced. A word that is in progress when lock is lost is discarded.
- R7: After lock returns, slots without a new frame rising edge are ignored. Capture resumes at the next frame edge.
- R8: A frame edge that arrives after 1 to 7 bits of a word drops that partial word without a valid strobe and sets align_err_o. That slot becomes bit 7 of a new word.
- R9: align_err_o stays set until err_clr_i is sampled high, which clears it at that edge. A new alignment error on the same edge takes priority over the clear.
- R10: Once eight bits are complete, further slots are ignored until the next frame rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receiver clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Marks a cycle carrying one bit slot |
| lane_i | input | 4 | One serial bit per lane |
| frame_i | input | 1 | Frame clock sampled each slot |
| lock_ni | input | 1 | Transmitter lock, low when locked (asynchronous) |
| fmt_offset_i | input | 1 | 1: input is offset binary, invert MSB |
| err_clr_i | input | 1 | Clears the alignment-error flag |
| word_o | output | 32 | Four assembled words, lane 0 in the low byte |
| valid_o | output | 1 | One-cycle strobe for a new word_o |
| align_err_o | output | 1 | Sticky early-frame-edge flag |

## Verification
The bench sends words MSB first with random gaps between slots, and checks bit order and lane placement against bytes it computes itself. A reversed shift or a swapped lane would show up as a wrong word. Lock is dropped partway through a word, and slots are then sent without a frame edge. A design that kept the partial word, or that resumed without waiting for an edge, would produce an extra or corrupt word, and the bench counts every strobe to catch this. An early frame edge, trailing slots after a complete word, and the format inversion are each driven directly. Mistakes in the flag's stickiness, the clear, or the MSB inversion would appear directly on align_err_o or word_o.

// File: rtl/adc_frame_rx_pkg.sv
package adc_frame_rx_pkg;
  localparam int NUM_LANES     = 4;
  localparam int BITS_PER_WORD = 8;
  localparam int SYNC_STAGES   = 2;
endpackage

// File: rtl/adc_frame_rx_sync.sv
module adc_frame_rx_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/adc_frame_rx_framer.sv
module adc_frame_rx_framer #(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic frame_i,
  input  logic locked_i,
  input  logic err_clr_i,
  output logic capture_o,
  output logic last_o,
  output logic valid_o,
  output logic align_err_o
);
  logic             frame_q;
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;
  logic             align_set;

  // frame edge is judged slot to slot, not cycle to cycle
  assign start     = bit_en_i & frame_i & ~frame_q;
  assign capture_o = locked_i & bit_en_i & (start | active_q);
  assign last_o    = locked_i & bit_en_i & ~start & active_q &
                     (cnt_q == CNT_W'(WORD_W - 1));
  assign align_set = locked_i & start & active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       frame_q <= 1'b0;
    else if (bit_en_i) frame_q <= frame_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!locked_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (bit_en_i) begin
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= CNT_W'(1);
      end else if (active_q) begin
        if (cnt_q == CNT_W'(WORD_W - 1)) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= last_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        align_err_o <= 1'b0;
    else if (align_set) align_err_o <= 1'b1;
    else if (err_clr_i) align_err_o <= 1'b0;
  end
endmodule

// File: rtl/adc_frame_rx_lane.sv
module adc_frame_rx_lane #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              capture_i,
  input  logic              last_i,
  input  logic              fmt_offset_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] nxt;

  assign nxt = {sh_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '0;
    else if (capture_i) sh_q <= nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_o <= '0;
    else if (last_i) word_o <= nxt ^ {fmt_offset_i, {(WORD_W-1){1'b0}}};
  end
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
  import adc_frame_rx_pkg::*;
#(
  parameter int LANES  = NUM_LANES,
  parameter int WORD_W = BITS_PER_WORD,
  localparam int OUT_W = LANES * WORD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic [LANES-1:0] lane_i,
  input  logic             frame_i,
  input  logic             lock_ni,
  input  logic             fmt_offset_i,
  input  logic             err_clr_i,
  output logic [OUT_W-1:0] word_o,
  output logic             valid_o,
  output logic             align_err_o
);
  logic lock_n_sync;
  logic capture;
  logic last;

  adc_frame_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_lock_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lock_ni),
    .q_o   (lock_n_sync)
  );

  adc_frame_rx_framer #(.WORD_W(WORD_W)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .frame_i    (frame_i),
    .locked_i   (~lock_n_sync),
    .err_clr_i  (err_clr_i),
    .capture_o  (capture),
    .last_o     (last),
    .valid_o    (valid_o),
    .align_err_o(align_err_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adc_frame_rx_lane #(.WORD_W(WORD_W)) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bit_i       (lane_i[g]),
      .capture_i   (capture),
      .last_i      (last),
      .fmt_offset_i(fmt_offset_i),
      .word_o      (word_o[g*WORD_W +: WORD_W])
    );
  end
endmodule

// File: rtl/adc_frame_rx_chk.sv
module adc_frame_rx_chk #(
  parameter int OUT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_en_i,
  input logic             frame_i,
  input logic             lock_ni,
  input logic             err_clr_i,
  input logic [OUT_W-1:0] word_o,
  input logic             valid_o,
  input logic             align_err_o
);
  assert_valid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_word_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));

  assert_valid_needs_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_en_i));

  assert_no_word_unlocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_ni, 3) |-> !valid_o);

  assert_err_on_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(align_err_o) |-> $past(bit_en_i && frame_i));

  assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_clr_i) && !$past(bit_en_i)) |-> !align_err_o);
endmodule

bind adc_frame_rx adc_frame_rx_chk #(.OUT_W(LANES * WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_en_i   (bit_en_i),
  .frame_i    (frame_i),
  .lock_ni    (lock_ni),
  .err_clr_i  (err_clr_i),
  .word_o     (word_o),
  .valid_o    (valid_o),
  .align_err_o(align_err_o)
);

// File: tb/adc_frame_rx_bench.sv
`timescale 1ns/1ps
module adc_frame_rx_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic [3:0]  lane_i = '0;
  logic        frame_i = 1'b0;
  logic        lock_ni = 1'b0;
  logic        fmt_offset_i = 1'b0;
  logic        err_clr_i = 1'b0;
  logic [31:0] word_o;
  logic        valid_o;
  logic        align_err_o;

  int errors = 0;
  int checks = 0;
  int vcnt = 0;
  int gap_max = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  adc_frame_rx u_adc_frame_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .lane_i(lane_i),
    .frame_i(frame_i), .lock_ni(lock_ni), .fmt_offset_i(fmt_offset_i),
    .err_clr_i(err_clr_i), .word_o(word_o), .valid_o(valid_o),
    .align_err_o(align_err_o)
  );

  always @(negedge clk_i) if (rst_ni && valid_o) vcnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] w, input bit fmt);
    return fmt ? (w ^ 32'h8080_8080) : w;
  endfunction

  function automatic logic [3:0] slot_bits(input logic [31:0] w, input int s);
    logic [3:0] b;
    for (int k = 0; k < 4; k++) b[k] = w[8*k + 7 - s];
    return b;
  endfunction

  // one enabled slot; returns at the negedge after its capture edge
  task automatic slot(input logic [3:0] bits, input bit f);
    @(negedge clk_i);
    lane_i = bits; frame_i = f; bit_en_i = 1'b1;
    @(negedge clk_i);
    bit_en_i = 1'b0;
    if (gap_max > 0) repeat ($urandom_range(gap_max)) @(negedge clk_i);
  endtask

  task automatic send_word(input logic [31:0] w, input bit fmt, input string req);
    int v0;
    fmt_offset_i = fmt;
    for (int s = 0; s < 7; s++) slot(slot_bits(w, s), s < 4);
    v0 = vcnt;
    @(negedge clk_i);
    lane_i = slot_bits(w, 7); frame_i = 1'b0; bit_en_i = 1'b1;
    @(negedge clk_i);
    bit_en_i = 1'b0;
    chk(valid_o === 1'b1, {req, " valid strobe"}, 32'(valid_o), 32'd1);
    chk(word_o === expect_word(w, fmt), req, word_o, expect_word(w, fmt));
    @(negedge clk_i);
    chk(valid_o === 1'b0 && vcnt == v0 + 1, "R3 single-cycle strobe", 32'(vcnt - v0), 32'd1);
  endtask

  task automatic send_part(input logic [31:0] w, input int from, input int upto);
    for (int s = from; s < upto; s++) slot(slot_bits(w, s), s < 4);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v0;
    logic [31:0] w;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(valid_o === 1'b0 && align_err_o === 1'b0, "R1 reset flags",
        {30'd0, valid_o, align_err_o}, 32'd0);
    chk(word_o === 32'd0, "R1 reset word", word_o, 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R2: slots before the first frame edge are ignored
    v0 = vcnt;
    slot(4'hF, 1'b0); slot(4'h0, 1'b0); slot(4'hA, 1'b0);
    chk(vcnt == v0, "R2 no word before frame edge", 32'(vcnt), 32'(v0));
    send_word(32'h8001_7F3C, 1'b0, "R2 R3 first word");
    send_word(32'h1234_5678, 1'b0, "R3 lane order MSB first");

    // R5: format inversion
    send_word(32'h0080_FF7F, 1'b1, "R5 offset binary inverts MSB");
    send_word(32'h0080_FF7F, 1'b0, "R5 twos complement passes");

    // R10: trailing slots without an edge are ignored
    v0 = vcnt;
    slot(4'hF, 1'b0); slot(4'h5, 1'b0); slot(4'h3, 1'b0);
    chk(vcnt == v0, "R10 trailing slots ignored", 32'(vcnt), 32'(v0));
    send_word(32'hDEAD_BEEF, 1'b0, "R10 next word after trailing slots");
    chk(align_err_o === 1'b0, "R10 no alignment error", 32'(align_err_o), 32'd0);

    // R6/R7: lock lost mid-word
    v0 = vcnt;
    send_part(32'hCAFE_F00D, 0, 4);
    @(negedge clk_i); lock_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    send_part(32'hCAFE_F00D, 4, 8);
    send_part(32'h5555_AAAA, 0, 8);
    chk(vcnt == v0, "R6 no word while unlocked", 32'(vcnt), 32'(v0));
    @(negedge clk_i); lock_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    send_part(32'h0F0F_0F0F, 4, 8);
    chk(vcnt == v0, "R7 no capture until frame edge", 32'(vcnt), 32'(v0));
    send_word(32'h3C5A_96E1, 1'b0, "R7 resume at frame edge");
    chk(align_err_o === 1'b0, "R6 lock loss is not an alignment error",
        32'(align_err_o), 32'd0);

    // R8: early frame edge
    v0 = vcnt;
    send_part(32'hFFFF_FFFF, 0, 5);
    send_word(32'h0102_0408, 1'b0, "R8 word after early edge");
    chk(vcnt == v0 + 1, "R8 partial word dropped", 32'(vcnt - v0), 32'd1);
    chk(align_err_o === 1'b1, "R8 alignment error set", 32'(align_err_o), 32'd1);

    // R9: sticky until cleared
    send_word(32'h7766_5544, 1'b1, "R9 word with flag set");
    chk(align_err_o === 1'b1, "R9 flag sticky", 32'(align_err_o), 32'd1);
    @(negedge clk_i); err_clr_i = 1'b1;
    @(negedge clk_i); err_clr_i = 1'b0;
    chk(align_err_o === 1'b0, "R9 flag cleared", 32'(align_err_o), 32'd0);

    // R4: random words with idle gaps between slots
    gap_max = 3;
    for (int n = 0; n < 40; n++) begin
      w = $urandom();
      send_word(w, 1'($urandom_range(1)), "R4 random word with gaps");
    end
    chk(align_err_o === 1'b0, "R4 gaps cause no alignment error", 32'(align_err_o), 32'd0);

    finish_run();
  end
endmodule